// File: doc/BRIEF.md
# CAN Channel Enable/Standby Mode Controller

This block moves a CAN channel between a standby mode and an enabled mode. Software writes a command bit that asks for a mode. The block reports the mode actually in effect on a separate status flag, because a mode change takes time. Leaving standby requires the bus to be idle. Entering standby waits until the channel is no longer using the bus.

On an enable request the controller watches the bit-time samples of the receive line. It enables the channel only after eleven recessive samples in a row. On a standby request it holds the channel in a draining state until the transmitter is idle. If an abort was requested, it also waits for the receiver to go idle. In standby the transmitter is forced recessive, the receiver is switched off and the channel's mailbox state is frozen. A software reset returns the block to clean standby from any state. The protocol engine is outside this block. It consumes the control outputs and supplies the busy indications.

`rst_ni` is asynchronous and active low. It is expected to be released synchronously to `clk_i`.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the controller is in standby: `st_standby_o`=1, `enabled_o`=0, `tx_recessive_o`=1, `rx_enable_o`=0, `freeze_o`=1.
- R2: The command bit does not change the mode at once. With `enable_cmd_i`=1 in standby, the next cycle shows `st_wait_idle_o`=1 and `enabled_o` still 0.
- R3: In the idle-wait state, `enabled_o` rises on the cycle after the clock edge at which the 11th consecutive recessive sample (`bit_strobe_i`=1, `rx_bit_i`=1) is taken, and not earlier.
- R4: A dominant sample (`bit_strobe_i`=1, `rx_bit_i`=0) during the idle wait restarts the count from zero. Cycles without `bit_strobe_i` leave the count unchanged.
- R5: If `enable_cmd_i` drops during the idle wait, the block returns to standby on the next cycle, and `enabled_o` is never raised.
- R6: With `enable_cmd_i`=0 in the enabled state, the block enters the drain state next cycle. It stays there, with `enabled_o`=1, while `tx_busy_i`=1.
- R7: After an abort pulse (`abort_req_i`=1), the drain state is also held while `rx_busy_i`=1. The drain state exits only when `tx_busy_i`=0 and `rx_busy_i`=0.
- R8: Without a pending abort, `rx_busy_i` has no effect on leaving the drain state. The drain state exits on the cycle after `tx_busy_i` is 0.
- R9: In standby and in the idle wait, `tx_recessive_o`=1, `rx_enable_o`=0 and `freeze_o`=1. In the enabled and drain states the three are inverted.
- R10: `soft_rst_i`=1 puts the block in standby on the next cycle from any state, and clears the idle count and any pending abort.
- R11: Re-asserting `enable_cmd_i` during the drain state does not cancel the drain. The block completes to standby, then starts a fresh idle wait.
- R12: Exactly one of the four state outputs is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous software reset to standby |
| enable_cmd_i | input | 1 | Requested mode: 1 enable, 0 standby |
| bit_strobe_i | input | 1 | One-cycle pulse per bit-time sample |
| rx_bit_i | input | 1 | Sampled receive bit, 1 recessive |
| tx_busy_i | input | 1 | Protocol engine is transmitting |
| rx_busy_i | input | 1 | Protocol engine is receiving |
| abort_req_i | input | 1 | Abort request pulse |
| enabled_o | output | 1 | True-state enabled flag |
| tx_recessive_o | output | 1 | Force transmit line recessive |
| rx_enable_o | output | 1 | Receiver enable |
| freeze_o | output | 1 | Freeze mailbox state |
| st_standby_o | output | 1 | Debug: standby state |
| st_wait_idle_o | output | 1 | Debug: waiting for bus idle |
| st_enabled_o | output | 1 | Debug: enabled state |
| st_drain_o | output | 1 | Debug: draining before standby |

## Verification
The bench places a single dominant sample after every possible run length of recessive samples. This catches a counter that fails to restart, or that enables one sample early or late. Such a design would raise `enabled_o` before the eleventh clean recessive sample.

Every combination of abort, transmitter-busy and receiver-busy is applied in the drain state. A design that ignored the pending abort would freeze the channel in the middle of a reception. A design that always waited on the receiver would stall standby for no reason.

Other cases cover withdrawing the command mid-wait, re-asserting it mid-drain, and a software reset from each state. These expose a flag raised without an idle bus, a drain that is cancelled, or a reset that is not clean.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY   = 2'd0,
    MODE_WAIT_IDLE = 2'd1,
    MODE_ENABLED   = 2'd2,
    MODE_DRAIN     = 2'd3
  } mode_e;

  localparam int unsigned MODE_COUNT = 4;

endpackage

// File: rtl/can_idle_counter.sv
module can_idle_counter #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic strobe_i,
  input  logic rx_bit_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i || strobe_i;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (strobe_i) begin
      if (!rx_bit_i)          cnt_d = '0;
      else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = !clear_i && strobe_i && rx_bit_i && (cnt_q == LAST);

endmodule

// File: rtl/can_abort_tracker.sv
module can_abort_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic abort_i,
  output logic pending_o
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = clear_i || abort_i;
    pend_d  = !clear_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pending_o = pend_q;

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  soft_rst_i,
  input  logic  enable_cmd_i,
  input  logic  idle_done_i,
  input  logic  tx_busy_i,
  input  logic  rx_busy_i,
  input  logic  abort_pend_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  logic  drain_clear;

  always_comb begin
    drain_clear = !tx_busy_i && (!abort_pend_i || !rx_busy_i);
    mode_d      = mode_q;
    if (soft_rst_i) begin
      mode_d = MODE_STANDBY;
    end else begin
      unique case (mode_q)
        MODE_STANDBY:   if (enable_cmd_i) mode_d = MODE_WAIT_IDLE;
        MODE_WAIT_IDLE: begin
          if (!enable_cmd_i)    mode_d = MODE_STANDBY;
          else if (idle_done_i) mode_d = MODE_ENABLED;
        end
        MODE_ENABLED:   if (!enable_cmd_i) mode_d = MODE_DRAIN;
        MODE_DRAIN:     if (drain_clear)   mode_d = MODE_STANDBY;
        default:        mode_d = MODE_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_STANDBY;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/can_mode_outputs.sv
module can_mode_outputs
  import can_mode_pkg::*;
(
  input  mode_e                 mode_i,
  output logic [MODE_COUNT-1:0] onehot_o,
  output logic                  enabled_o,
  output logic                  tx_recessive_o,
  output logic                  rx_enable_o,
  output logic                  freeze_o
);
  for (genvar s = 0; s < MODE_COUNT; s++) begin : g_decode
    assign onehot_o[s] = (mode_i == mode_e'(s));
  end

  logic on_bus;
  assign on_bus         = onehot_o[MODE_ENABLED] || onehot_o[MODE_DRAIN];
  assign enabled_o      = on_bus;
  assign rx_enable_o    = on_bus;
  assign tx_recessive_o = !on_bus;
  assign freeze_o       = !on_bus;

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic enable_cmd_i,
  input  logic bit_strobe_i,
  input  logic rx_bit_i,
  input  logic tx_busy_i,
  input  logic rx_busy_i,
  input  logic abort_req_i,
  output logic enabled_o,
  output logic tx_recessive_o,
  output logic rx_enable_o,
  output logic freeze_o,
  output logic st_standby_o,
  output logic st_wait_idle_o,
  output logic st_enabled_o,
  output logic st_drain_o
);
  mode_e                 mode;
  logic                  idle_done;
  logic                  abort_pend;
  logic [MODE_COUNT-1:0] onehot;

  can_idle_counter #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (soft_rst_i || (mode != MODE_WAIT_IDLE)),
    .strobe_i (bit_strobe_i),
    .rx_bit_i (rx_bit_i),
    .done_o   (idle_done)
  );

  can_abort_tracker u_abort (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (soft_rst_i || (mode == MODE_STANDBY)),
    .abort_i   (abort_req_i),
    .pending_o (abort_pend)
  );

  can_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .enable_cmd_i (enable_cmd_i),
    .idle_done_i  (idle_done),
    .tx_busy_i    (tx_busy_i),
    .rx_busy_i    (rx_busy_i),
    .abort_pend_i (abort_pend),
    .mode_o       (mode)
  );

  can_mode_outputs u_out (
    .mode_i         (mode),
    .onehot_o       (onehot),
    .enabled_o      (enabled_o),
    .tx_recessive_o (tx_recessive_o),
    .rx_enable_o    (rx_enable_o),
    .freeze_o       (freeze_o)
  );

  assign st_standby_o   = onehot[MODE_STANDBY];
  assign st_wait_idle_o = onehot[MODE_WAIT_IDLE];
  assign st_enabled_o   = onehot[MODE_ENABLED];
  assign st_drain_o     = onehot[MODE_DRAIN];

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
  parameter int unsigned IDLE_BITS = 11
) (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic enable_cmd_i,
  input logic bit_strobe_i,
  input logic rx_bit_i,
  input logic tx_busy_i,
  input logic enabled_o,
  input logic tx_recessive_o,
  input logic rx_enable_o,
  input logic freeze_o,
  input logic st_standby_o,
  input logic st_wait_idle_o,
  input logic st_enabled_o,
  input logic st_drain_o
);
  localparam int unsigned RUN_W = $clog2(IDLE_BITS + 1) + 1;

  // Run of recessive samples seen at the ports while waiting for idle.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          run_q <= '0;
    else if (soft_rst_i || !st_wait_idle_o) run_q <= '0;
    else if (bit_strobe_i && !rx_bit_i)   run_q <= '0;
    else if (bit_strobe_i)                run_q <= run_q + 1'b1;
  end

  a_r2_cmd_not_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_standby_o && enable_cmd_i && !soft_rst_i |=> st_wait_idle_o && !enabled_o);

  a_r3_idle_run_before_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_enabled_o) |-> ($past(run_q) == RUN_W'(IDLE_BITS - 1)) &&
                            $past(bit_strobe_i && rx_bit_i));

  a_r5_withdraw_to_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wait_idle_o && !enable_cmd_i |=> st_standby_o && !enabled_o);

  a_r6_drain_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_drain_o && tx_busy_i && !soft_rst_i |=> st_drain_o && enabled_o);

  a_r9_standby_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_standby_o || st_wait_idle_o) |-> tx_recessive_o && !rx_enable_o && freeze_o);

  a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> st_standby_o && !enabled_o);

  a_r12_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({st_standby_o, st_wait_idle_o, st_enabled_o, st_drain_o}) == 1);

endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(.IDLE_BITS(IDLE_BITS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .soft_rst_i     (soft_rst_i),
  .enable_cmd_i   (enable_cmd_i),
  .bit_strobe_i   (bit_strobe_i),
  .rx_bit_i       (rx_bit_i),
  .tx_busy_i      (tx_busy_i),
  .enabled_o      (enabled_o),
  .tx_recessive_o (tx_recessive_o),
  .rx_enable_o    (rx_enable_o),
  .freeze_o       (freeze_o),
  .st_standby_o   (st_standby_o),
  .st_wait_idle_o (st_wait_idle_o),
  .st_enabled_o   (st_enabled_o),
  .st_drain_o     (st_drain_o)
);

// File: tb/can_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_mode_ctrl_tb_top;
  localparam int unsigned IDLE = 11;
  // state vector order: {standby, wait_idle, enabled, drain}
  localparam logic [3:0] S_SB = 4'b1000, S_WI = 4'b0100, S_EN = 4'b0010, S_DR = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, cmd = 0, strobe = 0, rxb = 1, txbusy = 0, rxbusy = 0, abrt = 0;
  logic enabled, txrec, rxen, frz, s_sb, s_wi, s_en, s_dr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  can_mode_ctrl #(.IDLE_BITS(IDLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .enable_cmd_i(cmd),
    .bit_strobe_i(strobe), .rx_bit_i(rxb), .tx_busy_i(txbusy), .rx_busy_i(rxbusy),
    .abort_req_i(abrt), .enabled_o(enabled), .tx_recessive_o(txrec),
    .rx_enable_o(rxen), .freeze_o(frz), .st_standby_o(s_sb),
    .st_wait_idle_o(s_wi), .st_enabled_o(s_en), .st_drain_o(s_dr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] st();
    return {s_sb, s_wi, s_en, s_dr};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; soft_rst = 0; cmd = 0; strobe = 0; rxb = 1;
    txbusy = 0; rxbusy = 0; abrt = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  // one sample, then one idle cycle; returns after outputs settled
  task automatic sample_bit(input logic b);
    strobe = 1; rxb = b;
    tick();
    strobe = 0; rxb = 1;
    tick();
  endtask

  task automatic go_enabled();
    cmd = 1;
    tick();
    for (int i = 0; i < IDLE; i++) sample_bit(1'b1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 state", st(), S_SB);
    check("R1 outputs", {enabled, txrec, rxen, frz}, 4'b0101);

    // R2/R3/R4 sweep: k recessive, one dominant, then full run
    for (int k = 0; k < IDLE; k++) begin
      do_reset();
      cmd = 1;
      tick();
      check("R2 wait not enabled", {st(), enabled}, {S_WI, 1'b0});
      for (int i = 0; i < k; i++) sample_bit(1'b1);
      sample_bit(1'b0);
      // idle cycles without strobe do not advance
      tick(); tick();
      for (int i = 0; i < IDLE - 1; i++) sample_bit(1'b1);
      check("R4 restart after dominant", {st(), enabled}, {S_WI, 1'b0});
      check("R9 wait outputs", {txrec, rxen, frz}, 3'b101);
      strobe = 1; rxb = 1;
      tick();
      strobe = 0;
      check("R3 enabled after 11th recessive", {st(), enabled}, {S_EN, 1'b1});
      check("R9 enabled outputs", {txrec, rxen, frz}, 3'b010);
      check("R12 onehot", $countones(st()), 1);
    end

    // R5 withdraw during idle wait
    do_reset();
    cmd = 1; tick();
    for (int i = 0; i < 5; i++) sample_bit(1'b1);
    cmd = 0; tick();
    check("R5 back to standby", {st(), enabled}, {S_SB, 1'b0});
    cmd = 1; tick();
    for (int i = 0; i < IDLE - 6; i++) sample_bit(1'b1);
    check("R5 count restarted", {st(), enabled}, {S_WI, 1'b0});
    for (int i = 0; i < 6; i++) sample_bit(1'b1);
    check("R5 enable after fresh run", st(), S_EN);

    // R6/R7/R8 exhaustive over {abort, tx_busy, rx_busy}
    for (int c = 0; c < 8; c++) begin
      logic ab, tb, rb, leave;
      ab = c[2]; tb = c[1]; rb = c[0];
      leave = !tb && (!ab || !rb);
      do_reset();
      go_enabled();
      txbusy = tb; rxbusy = rb;
      if (ab) begin abrt = 1; tick(); abrt = 0; end
      cmd = 0;
      tick();
      check("R6 enters drain", {st(), enabled}, {S_DR, 1'b1});
      tick();
      check(ab ? "R7 drain exit with abort" : (tb ? "R6 drain held" : "R8 rx busy ignored"),
            st(), leave ? S_SB : S_DR);
      if (!leave) begin
        tick(); tick();
        check("R6 still draining", {st(), enabled}, {S_DR, 1'b1});
        txbusy = 0;
        tick();
        check("R7 held by rx busy", st(), (ab && rb) ? S_DR : S_SB);
        rxbusy = 0;
        tick();
        check("R7 exits when idle", st(), S_SB);
      end
      check("R9 standby outputs", {enabled, txrec, rxen, frz}, 4'b0101);
    end

    // R11 re-assert command during drain
    do_reset();
    go_enabled();
    txbusy = 1; cmd = 0; tick();
    cmd = 1; tick(); tick();
    check("R11 drain not cancelled", st(), S_DR);
    txbusy = 0; tick();
    check("R11 completes to standby", st(), S_SB);
    tick();
    check("R11 fresh idle wait", {st(), enabled}, {S_WI, 1'b0});

    // R10 software reset from each state
    for (int s = 0; s < 4; s++) begin
      do_reset();
      if (s >= 1) begin cmd = 1; tick(); end
      if (s == 1) for (int i = 0; i < 6; i++) sample_bit(1'b1);
      if (s >= 2) for (int i = 0; i < IDLE; i++) sample_bit(1'b1);
      if (s == 3) begin txbusy = 1; abrt = 1; cmd = 0; tick(); abrt = 0; end
      soft_rst = 1; tick(); soft_rst = 0;
      check("R10 soft reset to standby", {st(), enabled}, {S_SB, 1'b0});
      txbusy = 0; rxbusy = 1;
      // count and abort cleared: fresh enable needs a full run, drain ignores rx busy
      cmd = 1; tick();
      for (int i = 0; i < IDLE - 1; i++) sample_bit(1'b1);
      check("R10 idle count cleared", st(), S_WI);
      sample_bit(1'b1);
      check("R10 enable after full run", st(), S_EN);
      cmd = 0; tick(); tick();
      check("R10 abort cleared", st(), S_SB);
      rxbusy = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule